// File: doc/BRIEF.md
# Register Insertion Ring Node

This block is one station on a one-way, word-wide ring. Every ring word travels with a valid flag; a cleared flag marks an idle slot. While the station has nothing of its own to send, it copies each arriving word to its output one clock later. Words that belong to a message addressed to this station are taken off the ring, handed to a local receive port, and replaced by idle slots.

To transmit, the local client writes a complete message into an insertion FIFO. At the next message boundary on the ring input, the station splices that FIFO into the ring path. It then sends from the FIFO head and queues arriving traffic at the FIFO tail. Each idle slot that arrives shrinks the FIFO by one word. When the FIFO is empty, the station falls back to plain forwarding. The station counts as busy from the moment a message is accepted until its FIFO has drained. That busy state is the whole arbitration scheme: there is no token and no central arbiter.

The first word of a message is a header. Bits [15:12] hold the destination station ID and bits [3:0] hold the number of words that follow it. Other header bits carry no meaning here.

Top module: `ring_node`

## Requirements
- R1: With no insertion active, a valid ring input word not addressed here appears on the ring output exactly one clock later, unchanged.
- R2: A header whose bits [15:12] equal NODE_ID, and the number of following words given in its bits [3:0], are removed from the ring. They appear in order on rx_vld/rx_data one clock after arrival, and the ring output carries idle in their place.
- R3: The client writes the header first, one word per clock with tx_wr. busy is high from the clock after an accepted header until the insertion FIFO is empty again.
- R4: A tx_wr while busy is high and the message load has already completed has no effect: those words never reach any receiver.
- R5: A header whose count plus one exceeds DEPTH is rejected. tx_err pulses for one clock on the following cycle, nothing is loaded, and busy stays low.
- R6: Insertion starts only when the ring input is between messages. The loaded message leaves the ring output as one unbroken run of valid words.
- R7: During insertion, a valid arriving word not addressed here goes to the FIFO tail in the same clock as the head is sent, so occupancy is unchanged. An idle or removed arriving slot lowers occupancy by one.
- R8: When the last FIFO word is sent with no word queued behind it, the station returns to forwarding and busy falls on the next clock.
- R9: An idle slot on ring_out or on the receive port carries all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| ring_in_vld | input | 1 | Upstream word valid (0 = idle slot) |
| ring_in_data | input | DATA_W | Upstream word |
| ring_out_vld | output | 1 | Downstream word valid |
| ring_out_data | output | DATA_W | Downstream word |
| tx_wr | input | 1 | Client writes one message word |
| tx_data | input | DATA_W | Client message word, header first |
| tx_err | output | 1 | One-clock pulse: header rejected as too long |
| busy | output | 1 | Message loaded or insertion in progress |
| rx_vld | output | 1 | Delivered word valid |
| rx_data | output | DATA_W | Delivered word |

## Verification
Every output of the station is registered, so the ring output, the delivered word, busy and tx_err are all due on the clock after the input or client write that caused them. Insertion adds the FIFO occupancy to that single-clock latency. A four-station ring is compared against a behavioural model of each station, built from queues and integers, on every falling edge. Because inputs change only at falling edges, each comparison sees the values registered at the rising edge just before it. Single-purpose checks cover the reset state, the clock on which tx_err appears and busy rises, and the end-of-run word conservation and FIFO drain.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_LOAD = 2'd1,
    MODE_WAIT = 2'd2,
    MODE_INS  = 2'd3
  } node_mode_e;
endpackage

// File: rtl/ring_node_fifo.sv
module ring_node_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_d  = pop  ? step(rd_q) : rd_q;
    wr_d  = push ? step(wr_q) : wr_q;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;

  // R7: the tail never grows past the depth, and the head is never read from an empty queue
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (cnt_q < CNT_W'(DEPTH)));
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/ring_node_parse.sv
module ring_node_parse #(
  parameter int DATA_W  = 16,
  parameter int ID_W    = 4,
  parameter int LEN_W   = 4,
  parameter int NODE_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              take,
  output logic              boundary
);
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             mine_q, mine_d;
  logic             hdr, hit;

  assign hdr      = in_vld && (rem_q == '0);
  assign hit      = (in_data[DATA_W-1 -: ID_W] == ID_W'(NODE_ID));
  assign take     = in_vld && (hdr ? hit : mine_q);
  assign boundary = (rem_q == '0);

  always_comb begin
    rem_d  = rem_q;
    mine_d = mine_q;
    if (in_vld) begin
      if (hdr) begin
        rem_d  = in_data[LEN_W-1:0];
        mine_d = hit;
      end else begin
        rem_d  = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      mine_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      mine_q <= mine_d;
    end
  end

  // R2: a body word of a local message is always taken
  p_body_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !hdr && mine_q) |-> take);
endmodule

// File: rtl/ring_node.sv
module ring_node
  import ring_node_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ID_W    = 4,
  parameter int LEN_W   = 4,
  parameter int NODE_ID = 0,
  parameter int DEPTH   = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_in_vld,
  input  logic [DATA_W-1:0] ring_in_data,
  output logic              ring_out_vld,
  output logic [DATA_W-1:0] ring_out_data,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_err,
  output logic              busy,
  output logic              rx_vld,
  output logic [DATA_W-1:0] rx_data
);
  node_mode_e        mode_q, mode_d;
  logic [LEN_W-1:0]  load_q, load_d;
  logic              err_d;
  logic              out_vld_d, rx_vld_d;
  logic [DATA_W-1:0] out_data_d, rx_data_d;
  logic              take, boundary, ins_now, fwd;
  logic              f_push, f_pop;
  logic [DATA_W-1:0] f_wdata, f_head;
  logic [CNT_W-1:0]  f_cnt;
  logic [LEN_W-1:0]  tx_len;
  logic              too_long;

  ring_node_parse #(.DATA_W(DATA_W), .ID_W(ID_W), .LEN_W(LEN_W), .NODE_ID(NODE_ID)) u_parse (
    .clk(clk), .rst_n(rst_n), .in_vld(ring_in_vld), .in_data(ring_in_data),
    .take(take), .boundary(boundary));

  ring_node_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(f_push), .wdata(f_wdata), .pop(f_pop),
    .head(f_head), .count(f_cnt));

  assign tx_len   = tx_data[LEN_W-1:0];
  assign too_long = (int'(tx_len) + 1) > DEPTH;
  assign fwd      = ring_in_vld && !take;
  assign ins_now  = (mode_q == MODE_INS) || ((mode_q == MODE_WAIT) && boundary);

  always_comb begin
    mode_d     = mode_q;
    load_d     = load_q;
    err_d      = 1'b0;
    f_push     = 1'b0;
    f_pop      = 1'b0;
    f_wdata    = tx_data;
    out_vld_d  = 1'b0;
    out_data_d = '0;
    rx_vld_d   = take;
    rx_data_d  = take ? ring_in_data : '0;
    if (ins_now) begin
      out_vld_d  = 1'b1;
      out_data_d = f_head;
      f_pop      = 1'b1;
      if (fwd) begin
        f_push  = 1'b1;
        f_wdata = ring_in_data;
      end
      mode_d = (f_cnt == CNT_W'(1) && !fwd) ? MODE_PASS : MODE_INS;
    end else begin
      if (fwd) begin
        out_vld_d  = 1'b1;
        out_data_d = ring_in_data;
      end
      case (mode_q)
        MODE_PASS: if (tx_wr) begin
          if (too_long) begin
            err_d = 1'b1;
          end else begin
            f_push = 1'b1;
            load_d = tx_len;
            mode_d = (tx_len == '0) ? MODE_WAIT : MODE_LOAD;
          end
        end
        MODE_LOAD: if (tx_wr) begin
          f_push = 1'b1;
          load_d = load_q - 1'b1;
          if (load_q == LEN_W'(1)) mode_d = MODE_WAIT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q        <= MODE_PASS;
      load_q        <= '0;
      tx_err        <= 1'b0;
      ring_out_vld  <= 1'b0;
      ring_out_data <= '0;
      rx_vld        <= 1'b0;
      rx_data       <= '0;
    end else begin
      mode_q        <= mode_d;
      load_q        <= load_d;
      tx_err        <= err_d;
      ring_out_vld  <= out_vld_d;
      ring_out_data <= out_data_d;
      rx_vld        <= rx_vld_d;
      rx_data       <= rx_data_d;
    end
  end

  assign busy = (mode_q != MODE_PASS);

  // R1: forwarding adds exactly one clock
  p_pass_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_now && fwd) |=> (ring_out_vld && ring_out_data == $past(ring_in_data)));
  // R2: removed words reach the receive port and leave an idle slot
  p_deliver_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (rx_vld && rx_data == $past(ring_in_data)));
  p_remove_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ins_now) |=> !ring_out_vld);
  // R3: queued words imply busy
  p_busy_queued_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (f_cnt != '0) |-> busy);
  // R5: a rejected header leaves the station idle
  p_reject_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> !busy);
  // R7: occupancy kept by arriving traffic, lowered by idle slots
  p_occ_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_now && fwd) |=> (f_cnt == $past(f_cnt)));
  p_occ_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_now && !fwd) |=> (f_cnt == CNT_W'($past(f_cnt) - 1'b1)));
endmodule

// File: tb/ring_node_tb.sv
`timescale 1ns/1ps
module ring_node_tb;
  localparam int N     = 4;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        tx_wr [N];
  logic [15:0] tx_data [N];
  logic        o_v [N];
  logic [15:0] o_d [N];
  logic        r_v [N];
  logic [15:0] r_d [N];
  logic        bsy [N];
  logic        err [N];

  for (genvar g = 0; g < N; g++) begin : g_node
    if (g == 0) begin : g_first
      ring_node #(.NODE_ID(g), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ring_in_vld(o_v[(g + N - 1) % N]), .ring_in_data(o_d[(g + N - 1) % N]),
        .ring_out_vld(o_v[g]), .ring_out_data(o_d[g]),
        .tx_wr(tx_wr[g]), .tx_data(tx_data[g]), .tx_err(err[g]), .busy(bsy[g]),
        .rx_vld(r_v[g]), .rx_data(r_d[g]));
    end else begin : g_rest
      ring_node #(.NODE_ID(g), .DEPTH(DEPTH)) u_node (
        .clk(clk), .rst_n(rst_n),
        .ring_in_vld(o_v[(g + N - 1) % N]), .ring_in_data(o_d[(g + N - 1) % N]),
        .ring_out_vld(o_v[g]), .ring_out_data(o_d[g]),
        .tx_wr(tx_wr[g]), .tx_data(tx_data[g]), .tx_err(err[g]), .busy(bsy[g]),
        .rx_vld(r_v[g]), .rx_data(r_d[g]));
    end
  end

  // behavioural reference: one model per station
  int          m_mode [N];   // 0 forward, 1 loading, 2 waiting, 3 inserting
  logic [15:0] m_q [N][$];
  int          m_load [N];
  int          m_rem [N];
  bit          m_mine [N];
  bit          m_ov [N], m_rv [N], m_err [N];
  logic [15:0] m_od [N], m_rd [N];
  bit          t_v [N];
  logic [15:0] t_d [N];

  int checks = 0, errors = 0;
  int delivered [N];
  int expected [N];
  bit done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < N; n++) begin
        m_mode[n] = 0; m_q[n].delete(); m_load[n] = 0; m_rem[n] = 0; m_mine[n] = 0;
        m_ov[n] = 0; m_od[n] = 0; m_rv[n] = 0; m_rd[n] = 0; m_err[n] = 0;
      end
    end else begin
      for (int n = 0; n < N; n++) begin t_v[n] = m_ov[n]; t_d[n] = m_od[n]; end
      for (int n = 0; n < N; n++) begin
        automatic int          p    = (n + N - 1) % N;
        automatic bit          iv   = t_v[p];
        automatic logic [15:0] id   = t_d[p];
        automatic bit          hdr  = iv && (m_rem[n] == 0);
        automatic bit          take = iv && (hdr ? (int'(id[15:12]) == n) : m_mine[n]);
        automatic bit          ins  = (m_mode[n] == 3) || (m_mode[n] == 2 && m_rem[n] == 0);
        m_err[n] = 0;
        m_rv[n]  = take;
        m_rd[n]  = take ? id : 16'h0;
        if (ins) begin
          m_od[n] = m_q[n].pop_front();
          m_ov[n] = 1;
          if (iv && !take) m_q[n].push_back(id);
          m_mode[n] = (m_q[n].size() == 0) ? 0 : 3;
        end else begin
          m_ov[n] = iv && !take;
          m_od[n] = (iv && !take) ? id : 16'h0;
          if (m_mode[n] == 0 && tx_wr[n]) begin
            if (int'(tx_data[n][3:0]) + 1 > DEPTH) m_err[n] = 1;
            else begin
              m_q[n].push_back(tx_data[n]);
              m_load[n] = int'(tx_data[n][3:0]);
              m_mode[n] = (m_load[n] == 0) ? 2 : 1;
            end
          end else if (m_mode[n] == 1 && tx_wr[n]) begin
            m_q[n].push_back(tx_data[n]);
            m_load[n]--;
            if (m_load[n] == 0) m_mode[n] = 2;
          end
        end
        if (iv) begin
          if (hdr) begin m_rem[n] = int'(id[3:0]); m_mine[n] = (int'(id[15:12]) == n); end
          else m_rem[n]--;
        end
      end
    end
  end

  task automatic chk(string req, string what, int n, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s node%0d %s actual=%0h expected=%0h", req, n, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int n = 0; n < N; n++) begin
        chk("R1 R6 R7 R9", "ring_out", n, {15'h0, o_v[n], o_d[n]}, {15'h0, m_ov[n], m_od[n]});
        chk("R2 R9", "rx", n, {15'h0, r_v[n], r_d[n]}, {15'h0, m_rv[n], m_rd[n]});
        chk("R3 R8", "busy", n, 32'(bsy[n]), 32'(m_mode[n] != 0));
        chk("R5", "tx_err", n, 32'(err[n]), 32'(m_err[n]));
        if (r_v[n]) delivered[n]++;
      end
    end
  end

  task automatic send(int n, int dest, int cnt, int tag, bit counted);
    for (int k = 0; k <= cnt; k++) begin
      @(negedge clk);
      tx_wr[n]   = 1'b1;
      tx_data[n] = (k == 0) ? {4'(dest), 8'(tag), 4'(cnt)} : {4'(n), 8'(tag), 4'(k)};
    end
    @(negedge clk);
    tx_wr[n] = 1'b0;
    if (counted) expected[dest] += cnt + 1;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      summary();
    end
  end

  initial begin
    for (int n = 0; n < N; n++) begin
      tx_wr[n] = 0; tx_data[n] = 0; delivered[n] = 0; expected[n] = 0;
    end
    repeat (3) @(negedge clk);
    for (int n = 0; n < N; n++)   // R1 R3: quiet reset state
      chk("R1 R3", "reset outputs", n, {28'h0, o_v[n], r_v[n], bsy[n], err[n]}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: single message, 0 -> 2
    send(0, 2, 3, 8'h11, 1);
    repeat (20) @(negedge clk);

    // R6 R7: four stations send at once, traffic crosses live insertions
    fork
      send(0, 2, 4, 8'h21, 1);
      send(1, 3, 2, 8'h22, 1);
      send(2, 0, 0, 8'h23, 1);
      send(3, 1, 5, 8'h24, 1);
    join
    fork
      send(2, 1, 3, 8'h25, 1);
      send(1, 0, 1, 8'h26, 1);
    join
    repeat (40) @(negedge clk);

    // R5: too-long header rejected
    tx_wr[1] = 1'b1;
    tx_data[1] = {4'd3, 8'h31, 4'd9};
    @(negedge clk);
    tx_wr[1] = 1'b0;
    chk("R5", "err pulse", 1, 32'(err[1]), 32'd1);
    chk("R5", "busy after reject", 1, 32'(bsy[1]), 32'd0);
    @(negedge clk);
    chk("R5", "err single clock", 1, 32'(err[1]), 32'd0);

    // R3 R4: writes while busy are dropped
    send(0, 2, 6, 8'h41, 1);
    chk("R3", "busy after load", 0, 32'(bsy[0]), 32'd1);
    send(0, 3, 1, 8'h42, 0);
    repeat (60) @(negedge clk);

    for (int n = 0; n < N; n++) begin
      chk("R8", "drained idle", n, 32'(bsy[n]), 32'd0);
      chk("R2 R4", "words delivered", n, 32'(delivered[n]), 32'(expected[n]));
    end
    done = 1;
    summary();
  end
endmodule